// File: doc/BRIEF.md
# Four-Digit Minutes:Seconds Stopwatch with Multiplexed Display

This block counts elapsed time as minutes and seconds in BCD and shows it on a four-digit common-anode seven-segment display. Only one digit is lit at a time. A rotating one-cold select line picks the digit, and the matching segment pattern comes out on a shared active-low segment bus. A free-running divider on the system clock produces a one-second advance pulse. That pulse only has effect while the stopwatch is running.

Three active-low push buttons control the count: clear, pause and start. Each button passes through a two-stage synchronizer and a stability filter. Only a filtered press is acted on; the release is not. Clear returns the count to 00:00, stops the count and restarts the divider. Pause freezes both the count and the divider. Start resumes counting from where the divider stopped.

Top module: `stopwatch_scan`

## Requirements
- R1: While reset is asserted (synchronous, active low), `dig_sel_n` is 4'b1110 and `seg_n` is 8'hFF. After reset the count is 00:00 and the stopwatch is stopped.
- R2: `dig_sel_n` always has exactly one low bit. It rotates toward the next higher bit (1110, 1101, 1011, 0111, then back to 1110) once every SCAN_DIV clocks, and never changes in between.
- R3: Low bit 0 of `dig_sel_n` selects seconds units, bit 1 seconds tens, bit 2 minutes units and bit 3 minutes tens. `seg_n` shows the digit that was selected two clocks earlier, because there are two register stages: digit capture, then segment decode.
- R4: Segment codes are active low with bit 7 as the decimal point. Digits 0 to 9 are C0, F9, A4, B0, 99, 92, 82, F8, 80, 90 (hex). The decimal point is lit (bit 7 = 0) only on the minutes-units digit.
- R5: While running, the count advances by one second each time TICK_DIV clocks have been counted. The first advance comes TICK_DIV clocks after a start from a cleared state takes effect.
- R6: Seconds units wrap 9 to 0 with a carry, and seconds tens wrap 5 to 0 with a carry into minutes. The count 59:59 advances to 00:00.
- R7: While paused or stopped, both the count and the partial second in the divider are held. After start the count continues with the remaining fraction, and the display keeps scanning.
- R8: A clear press sets the count to 00:00, stops counting and zeroes the divider. Clear wins over a start or pause press filtered in the same cycle.
- R9: A key acts only after its synchronized level has been low for DEB_LEN consecutive clocks. It acts once per press. Shorter low pulses and key releases have no effect.
- R10: When start and pause presses are filtered in the same cycle (and clear is not pressed), start wins and counting runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_clear_n | input | 1 | Clear button, active low, asynchronous |
| key_pause_n | input | 1 | Pause button, active low, asynchronous |
| key_start_n | input | 1 | Start button, active low, asynchronous |
| dig_sel_n | output | 4 | One-cold digit select, bit 0 = seconds units |
| seg_n | output | 8 | Active-low segments, bit 7 = decimal point |

## Verification
The bench builds the block with TICK_DIV = 20, SCAN_DIV = 4 and DEB_LEN = 3. A simulated second is therefore twenty clocks, and a full digit scan takes sixteen clocks. With these values a run through the whole hour, including the 59:59 to 00:00 rollover, fits in about seventy thousand clocks. The short filter length also lets the bench drive glitches shorter and longer than the threshold. Because the divider is so short, pausing part-way through a second and resuming can be compared exactly against the reference model on every clock.

// File: rtl/sw_pkg.sv
// Shared types and helpers for the stopwatch display block.
// Assumes BCD digits; any code above 9 decodes to a dark digit.
package sw_pkg;

    typedef logic [3:0] bcd_t;

    typedef struct packed {
        bcd_t min_tens;
        bcd_t min_ones;
        bcd_t sec_tens;
        bcd_t sec_ones;
    } mmss_t;

    typedef enum logic [1:0] {
        RUN_IDLE   = 2'd0,
        RUN_ACTIVE = 2'd1,
        RUN_HELD   = 2'd2
    } run_state_t;

    localparam logic [7:0] SEG_DARK  = 8'hFF;
    localparam logic [7:0] DP_ON_MSK = 8'h7F;

    // Active-low seven-segment pattern for one BCD digit, decimal point off.
    function automatic logic [7:0] bcd_to_seg(input bcd_t v);
        logic [7:0] p;
        case (v)
            4'd0:    p = 8'hC0;
            4'd1:    p = 8'hF9;
            4'd2:    p = 8'hA4;
            4'd3:    p = 8'hB0;
            4'd4:    p = 8'h99;
            4'd5:    p = 8'h92;
            4'd6:    p = 8'h82;
            4'd7:    p = 8'hF8;
            4'd8:    p = 8'h80;
            4'd9:    p = 8'h90;
            default: p = SEG_DARK;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/key_filter.sv
// Push-button conditioner: two-flop synchronizer, then a stability filter.
// Emits a one-clock pulse when the synchronized level has been low for
// DEB_LEN consecutive clocks. Assumes an active-low key that idles high.
module key_filter #(
    parameter int DEB_LEN = 500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_n_i,
    output logic press_o
);
    localparam int CNT_W = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_LEN - 1);

    logic             sync1_q, sync2_q;
    logic             level_q;
    logic [CNT_W-1:0] run_cnt_q;
    logic             press_q;

    // Bring the asynchronous key into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= key_n_i;
            sync2_q <= sync1_q;
        end
    end

    // Accept a new level after DEB_LEN differing samples; pulse on press.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q   <= 1'b1;
            run_cnt_q <= '0;
            press_q   <= 1'b0;
        end else begin
            press_q <= (!sync2_q) && level_q && (run_cnt_q == CNT_LAST);
            if (sync2_q == level_q) begin
                run_cnt_q <= '0;
            end else if (run_cnt_q == CNT_LAST) begin
                level_q   <= sync2_q;
                run_cnt_q <= '0;
            end else begin
                run_cnt_q <= run_cnt_q + 1'b1;
            end
        end
    end

    assign press_o = press_q;

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        press_q |=> !press_q);

    // R9
    press_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(press_q) |-> !level_q);

endmodule

// File: rtl/sw_counter.sv
// Run-control state machine, one-second divider and BCD mm:ss count.
// Assumes single-cycle press pulses; clear > start > pause in priority.
// The divider advances only while running, so a pause keeps the fraction.
module sw_counter
    import sw_pkg::*;
#(
    parameter int TICK_DIV = 50_000_000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr_i,
    input  logic  pause_i,
    input  logic  start_i,
    output mmss_t time_o
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    run_state_t       state_q;
    logic [DIV_W-1:0] div_q;
    mmss_t            time_q;
    mmss_t            time_inc;
    logic             tick;

    assign tick = (state_q == RUN_ACTIVE) && (div_q == DIV_LAST);

    // BCD successor of the current count with minute and hour wrap.
    always_comb begin
        time_inc = time_q;
        if (time_q.sec_ones == 4'd9) begin
            time_inc.sec_ones = 4'd0;
            if (time_q.sec_tens == 4'd5) begin
                time_inc.sec_tens = 4'd0;
                if (time_q.min_ones == 4'd9) begin
                    time_inc.min_ones = 4'd0;
                    if (time_q.min_tens == 4'd5) begin
                        time_inc.min_tens = 4'd0;
                    end else begin
                        time_inc.min_tens = time_q.min_tens + 4'd1;
                    end
                end else begin
                    time_inc.min_ones = time_q.min_ones + 4'd1;
                end
            end else begin
                time_inc.sec_tens = time_q.sec_tens + 4'd1;
            end
        end else begin
            time_inc.sec_ones = time_q.sec_ones + 4'd1;
        end
    end

    // Divider and count: advance while running, zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            time_q <= '0;
        end else if (clr_i) begin
            div_q  <= '0;
            time_q <= '0;
        end else if (state_q == RUN_ACTIVE) begin
            if (tick) begin
                div_q  <= '0;
                time_q <= time_inc;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    // Run control: clear wins, then start, then pause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RUN_IDLE;
        end else if (clr_i) begin
            state_q <= RUN_IDLE;
        end else if (start_i) begin
            state_q <= RUN_ACTIVE;
        end else if (pause_i && state_q == RUN_ACTIVE) begin
            state_q <= RUN_HELD;
        end
    end

    assign time_o = time_q;

    // R6
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        time_q.sec_ones <= 4'd9 && time_q.sec_tens <= 4'd5 &&
        time_q.min_ones <= 4'd9 && time_q.min_tens <= 4'd5);

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (time_q == '0) && (div_q == '0) && (state_q == RUN_IDLE));

    // R7
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && state_q != RUN_ACTIVE) |=> $stable(time_q) && $stable(div_q));

    // R5
    advance_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && div_q != DIV_LAST) |=> $stable(time_q));

endmodule

// File: rtl/sw_scan.sv
// Display scan: rotating one-cold digit select, registered digit capture,
// registered segment decode. Assumes the count is valid BCD.
// seg_n_o therefore trails dig_sel_n_o by two clocks.
module sw_scan
    import sw_pkg::*;
#(
    parameter int SCAN_DIV = 1000,
    parameter int DIGITS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mmss_t             time_i,
    output logic [DIGITS-1:0] dig_sel_n_o,
    output logic [7:0]        seg_n_o
);
    localparam int SCN_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
    localparam logic [SCN_W-1:0] SCN_LAST = SCN_W'(SCAN_DIV - 1);
    localparam logic [DIGITS-1:0] SEL_INIT = ~DIGITS'(1);

    logic [SCN_W-1:0]  scan_cnt_q;
    logic [DIGITS-1:0] sel_q;
    bcd_t              dval_q;
    logic              dp_q;
    logic [7:0]        seg_q;
    bcd_t              digit_pick;
    logic              dp_pick;

    // Scan interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_cnt_q <= '0;
        end else if (scan_cnt_q == SCN_LAST) begin
            scan_cnt_q <= '0;
        end else begin
            scan_cnt_q <= scan_cnt_q + 1'b1;
        end
    end

    // Rotate the low bit one place on each scan wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SEL_INIT;
        end else if (scan_cnt_q == SCN_LAST) begin
            sel_q <= {sel_q[DIGITS-2:0], sel_q[DIGITS-1]};
        end
    end

    // Digit and decimal point belonging to the current select.
    always_comb begin
        digit_pick = 4'hF;
        dp_pick    = 1'b0;
        case (sel_q)
            4'b1110: digit_pick = time_i.sec_ones;
            4'b1101: digit_pick = time_i.sec_tens;
            4'b1011: begin
                digit_pick = time_i.min_ones;
                dp_pick    = 1'b1;
            end
            4'b0111: digit_pick = time_i.min_tens;
            default: digit_pick = 4'hF;
        endcase
    end

    // First stage: capture the selected digit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dval_q <= 4'd0;
            dp_q   <= 1'b0;
        end else begin
            dval_q <= digit_pick;
            dp_q   <= dp_pick;
        end
    end

    // Second stage: decode to active-low segments.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= SEG_DARK;
        end else begin
            seg_q <= bcd_to_seg(dval_q) & (dp_q ? DP_ON_MSK : SEG_DARK);
        end
    end

    assign dig_sel_n_o = sel_q;
    assign seg_n_o     = seg_q;

    // R2
    sel_onecold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_q) == DIGITS - 1);

    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_cnt_q != SCN_LAST) |=> $stable(sel_q));

    // R4
    dp_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seg_q[7]) |-> $past(sel_q, 2) == 4'b1011);

endmodule

// File: rtl/stopwatch_scan.sv
// Top level: three key conditioners, the run/count core and the display
// scanner. Assumes a 50 MHz clock for the default dividers.
module stopwatch_scan
    import sw_pkg::*;
#(
    parameter int TICK_DIV = 50_000_000,
    parameter int SCAN_DIV = 1000,
    parameter int DEB_LEN  = 500_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_clear_n,
    input  logic       key_pause_n,
    input  logic       key_start_n,
    output logic [3:0] dig_sel_n,
    output logic [7:0] seg_n
);
    localparam int NKEYS = 3;

    logic [NKEYS-1:0] keys_n;
    logic [NKEYS-1:0] press;
    mmss_t            count;

    assign keys_n = {key_start_n, key_pause_n, key_clear_n};

    // One conditioner per button: index 0 clear, 1 pause, 2 start.
    generate
        for (genvar k = 0; k < NKEYS; k++) begin : g_key
            key_filter #(.DEB_LEN(DEB_LEN)) u_filt (
                .clk     (clk),
                .rst_n   (rst_n),
                .key_n_i (keys_n[k]),
                .press_o (press[k])
            );
        end
    endgenerate

    sw_counter #(.TICK_DIV(TICK_DIV)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (press[0]),
        .pause_i (press[1]),
        .start_i (press[2]),
        .time_o  (count)
    );

    sw_scan #(.SCAN_DIV(SCAN_DIV), .DIGITS(4)) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .time_i      (count),
        .dig_sel_n_o (dig_sel_n),
        .seg_n_o     (seg_n)
    );

endmodule

// File: tb/stopwatch_scan_test.sv
`timescale 1ns/1ps
module stopwatch_scan_test;
    localparam int TICK = 20;
    localparam int SCAN = 4;
    localparam int DEB  = 3;
    localparam int WDOG = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kc = 1'b1, kp = 1'b1, ks = 1'b1;
    logic [3:0] dig_sel_n;
    logic [7:0] seg_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string phase = "R1 reset";
    bit model_ok = 0;

    // Behavioural reference state.
    bit m_s1[3], m_s2[3], m_lvl[3], m_press[3];
    int m_cnt[3];
    bit m_run;
    int m_div, m_secs, m_scnt, m_pos, m_dval;
    bit m_dp;
    logic [7:0] m_seg;

    stopwatch_scan #(.TICK_DIV(TICK), .SCAN_DIV(SCAN), .DEB_LEN(DEB)) uut (
        .clk(clk), .rst_n(rst_n), .key_clear_n(kc), .key_pause_n(kp),
        .key_start_n(ks), .dig_sel_n(dig_sel_n), .seg_n(seg_n));

    always #4 clk = ~clk;

    function automatic logic [7:0] pat(input int v, input bit dp);
        logic [7:0] p;
        case (v)
            0: p = 8'hC0; 1: p = 8'hF9; 2: p = 8'hA4; 3: p = 8'hB0;
            4: p = 8'h99; 5: p = 8'h92; 6: p = 8'h82; 7: p = 8'hF8;
            8: p = 8'h80; 9: p = 8'h90; default: p = 8'hFF;
        endcase
        if (dp) p[7] = 1'b0;
        return p;
    endfunction

    function automatic int digit_of(input int secs, input int pos);
        int ss = secs % 60;
        int mm = secs / 60;
        case (pos)
            0: return ss % 10;
            1: return ss / 10;
            2: return mm % 10;
            default: return mm / 10;
        endcase
    endfunction

    // Reference model advanced on each rising edge.
    always @(posedge clk) begin
        bit keyv[3];
        keyv[0] = kc; keyv[1] = kp; keyv[2] = ks;
        model_ok <= 1;
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) begin
                m_s1[k] = 1; m_s2[k] = 1; m_lvl[k] = 1; m_cnt[k] = 0; m_press[k] = 0;
            end
            m_run = 0; m_div = 0; m_secs = 0; m_scnt = 0; m_pos = 0;
            m_dval = 0; m_dp = 0; m_seg = 8'hFF;
        end else begin
            m_seg = pat(m_dval, m_dp);
            m_dval = digit_of(m_secs, m_pos);
            m_dp = (m_pos == 2);
            if (m_scnt == SCAN - 1) begin m_scnt = 0; m_pos = (m_pos + 1) % 4; end
            else m_scnt++;
            if (m_press[0]) begin
                m_run = 0; m_div = 0; m_secs = 0;
            end else begin
                if (m_run) begin
                    if (m_div == TICK - 1) begin m_div = 0; m_secs = (m_secs + 1) % 3600; end
                    else m_div++;
                end
                if (m_press[2]) m_run = 1;
                else if (m_press[1]) m_run = 0;
            end
            for (int k = 0; k < 3; k++) begin
                bit np;
                np = (m_s2[k] == 0) && m_lvl[k] && (m_cnt[k] == DEB - 1);
                if (m_s2[k] == m_lvl[k]) m_cnt[k] = 0;
                else if (m_cnt[k] == DEB - 1) begin m_lvl[k] = m_s2[k]; m_cnt[k] = 0; end
                else m_cnt[k]++;
                m_s2[k] = m_s1[k];
                m_s1[k] = keyv[k];
                m_press[k] = np;
            end
        end
    end

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (model_ok) begin
            logic [3:0] es;
            es = ~(4'b0001 << m_pos);
            checks++;
            if (dig_sel_n !== es || seg_n !== m_seg) begin
                errors++;
                $display("FAIL %s (R2/R3 model): sel=%b seg=%h expected sel=%b seg=%h",
                         phase, dig_sel_n, seg_n, es, m_seg);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            checks++; errors++;
            $display("FAIL R5 watchdog: cycles=%0d expected below %0d", cyc, WDOG);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Read all four digits from the scan and compare with mm:ss.
    task automatic read_time(input int mm, input int ss, input string tag);
        for (int p = 0; p < 4; p++) begin
            logic [3:0] want;
            int secs;
            logic [7:0] e;
            want = ~(4'b0001 << p);
            secs = mm * 60 + ss;
            while (dig_sel_n == want) @(negedge clk);
            while (dig_sel_n != want) @(negedge clk);
            repeat (2) @(negedge clk);
            e = pat(digit_of(secs, p), p == 2);
            check(seg_n === e, $sformatf("%s R3 R4 digit %0d", tag, p), seg_n, e);
        end
    endtask

    task automatic press(input bit c, input bit p, input bit s);
        @(negedge clk);
        kc = !c; kp = !p; ks = !s;
        repeat (DEB + 4) @(negedge clk);
        kc = 1; kp = 1; ks = 1;
        repeat (DEB + 4) @(negedge clk);
    endtask

    task automatic run_for(input int n);
        press(0, 0, 1);
        repeat (n * TICK - 9) @(negedge clk);
        press(0, 1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(dig_sel_n === 4'b1110, "R1 reset select", {4'h0, dig_sel_n}, 8'h0E);
        check(seg_n === 8'hFF, "R1 reset segments", seg_n, 8'hFF);
        rst_n = 1;

        phase = "R2 scan";
        begin
            int n = 0;
            while (dig_sel_n != 4'b1101) @(negedge clk);
            while (dig_sel_n == 4'b1101) begin n++; @(negedge clk); end
            check(n == SCAN, "R2 scan period", 8'(n), 8'(SCAN));
            check(dig_sel_n === 4'b1011, "R2 rotate order", {4'h0, dig_sel_n}, 8'h0B);
        end

        phase = "R1 idle";
        read_time(0, 0, "R1 idle zero");
        repeat (3 * TICK) @(negedge clk);
        read_time(0, 0, "R1 stopped after reset");

        phase = "R5 run";
        run_for(3);
        read_time(0, 3, "R5 three seconds");

        phase = "R7 pause";
        repeat (100) @(negedge clk);
        read_time(0, 3, "R7 frozen");

        phase = "R9 glitch";
        @(negedge clk); ks = 0; @(negedge clk); ks = 1;
        repeat (5) @(negedge clk);
        ks = 0; repeat (2) @(negedge clk); ks = 1;
        repeat (5) @(negedge clk);
        kc = 0; repeat (2) @(negedge clk); kc = 1;
        repeat (60) @(negedge clk);
        read_time(0, 3, "R9 short pulses ignored");

        phase = "R7 resume";
        run_for(1);
        read_time(0, 4, "R7 fraction kept");

        phase = "R8 clear";
        press(1, 0, 0);
        read_time(0, 0, "R8 clear while held");
        press(0, 0, 1);
        repeat (40) @(negedge clk);
        press(1, 0, 0);
        repeat (60) @(negedge clk);
        read_time(0, 0, "R8 clear stops run");
        press(1, 0, 1);
        repeat (60) @(negedge clk);
        read_time(0, 0, "R8 clear beats start");

        phase = "R10 start+pause";
        press(0, 1, 1);
        repeat (55) @(negedge clk);
        press(0, 1, 0);
        read_time(0, 3, "R10 start wins");

        phase = "R6 minute carry";
        press(1, 0, 0);
        run_for(61);
        read_time(1, 1, "R6 minute carry");

        phase = "R6 hour wrap";
        press(1, 0, 0);
        run_for(3601);
        read_time(0, 1, "R6 59:59 wrap");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule